// File: doc/BRIEF.md
# Branch Expander with Static Prediction

This block takes one decoded branch at a time and turns it into a fetch redirect plus a short run of internal micro-ops. Each branch carries a 4-bit condition code, a signed word offset, a link flag and the address of the branch instruction. The block forms the destination as the instruction address plus 8 plus four times the offset. It decides from the condition and the sign of the offset whether to steer fetch at once.

Prediction is static. An unconditional branch, and a conditional branch that jumps backwards, send fetch to the destination one cycle after the branch is accepted. A conditional branch that jumps forwards, or by zero, leaves fetch alone. Mispredictions are repaired by conditional micro-ops that the pipeline runs later. One kind carries the opposite condition and puts fetch back on the fall-through path. Another carries the branch's own condition and moves fetch to the destination. For a branch with link, a further micro-op writes the return address into the link register, so the link register changes only when the branch really goes.

Micro-ops leave through a valid/ready port, one per accepted transfer. No new branch is taken in while any micro-op of the previous one is still waiting.

Top module: `bx_expander`

## Requirements
- R1: After reset, `redir_valid`, `uop_valid` are 0 and `in_ready` is 1.
- R2: A branch is accepted on a clock edge where `in_valid` and `in_ready` are both 1. When a redirect is made, `redir_valid` is 1 for exactly the next cycle, with `redir_pc` = (`in_addr` + 8 + 4 × signed `in_offset`) modulo 2^AW. No redirect appears in a cycle that does not follow an acceptance.
- R3: Condition code 4'hE means "always". A branch with cond 4'hE and link 0 redirects and emits no micro-op.
- R4: A branch with a condition other than 4'hE, link 0 and a negative offset redirects. It emits one micro-op: cond = branch cond with bit 0 inverted, `uop_to_link` = 0, `uop_flush` = 1, `uop_value` = `in_addr` + 4.
- R5: A branch with a condition other than 4'hE, link 0 and an offset of zero or more does not redirect. It emits one micro-op: cond = branch cond, `uop_to_link` = 0, `uop_flush` = 1, `uop_value` = destination.
- R6: A branch with cond 4'hE and link 1 redirects and emits one micro-op: cond 4'hE, `uop_to_link` = 1, `uop_flush` = 0, `uop_value` = `in_addr` + 4.
- R7: A branch with a condition other than 4'hE and link 1 redirects whatever the offset sign. It emits two micro-ops in order. The first has the inverted condition, `uop_to_link` = 0, `uop_flush` = 1 and value `in_addr` + 4. The second has the branch cond, `uop_to_link` = 1, `uop_flush` = 0 and value `in_addr` + 4.
- R8: While a micro-op is pending, `in_ready` is 0 and `in_valid` has no effect on any output. A pending micro-op holds all its fields until `uop_ready` is 1.
- R9: `uop_valid` drops in the cycle after the last micro-op of a branch is transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A branch is offered |
| in_ready | output | 1 | Block can take a branch |
| in_cond | input | 4 | Condition code of the branch (4'hE = always) |
| in_link | input | 1 | Branch also writes the link register |
| in_offset | input | OW | Signed offset in words |
| in_addr | input | AW | Address of the branch instruction |
| redir_valid | output | 1 | Redirect fetch this cycle |
| redir_pc | output | AW | New fetch address |
| uop_valid | output | 1 | A micro-op is offered |
| uop_ready | input | 1 | Pipeline takes the micro-op |
| uop_cond | output | 4 | Condition the micro-op executes under |
| uop_to_link | output | 1 | 1: writes the link register, 0: writes the PC |
| uop_flush | output | 1 | Micro-op flushes younger work when it executes |
| uop_value | output | AW | Value the micro-op writes |

## Verification
The assertions check these properties on every cycle: the redirect pulse follows only an acceptance and carries the computed destination, intake stays closed while a micro-op is pending, a stalled micro-op holds steady, and a link write never flushes. The choice of redirect, the number of micro-ops and their order, the inverted or kept condition, and the value each micro-op carries depend on the combination of condition, link flag and offset sign. Only the bench's sweep over every condition, both link settings and all offsets of the small configuration shows those.

// File: rtl/bx_pkg.sv
package bx_pkg;

  localparam logic [3:0] COND_ALWAYS = 4'hE;

  // Control part of one emitted micro-op
  typedef struct packed {
    logic [3:0] cond;
    logic       to_link;
    logic       flush;
  } uop_ctl_t;

  // Opposite condition: the codes come in pairs differing in bit 0
  function automatic logic [3:0] cond_invert(input logic [3:0] c);
    return {c[3:1], ~c[0]};
  endfunction

endpackage

// File: rtl/bx_target.sv
module bx_target #(
  parameter int AW = 32,
  parameter int OW = 24
) (
  input  logic [AW-1:0] addr,
  input  logic [OW-1:0] offset,
  output logic [AW-1:0] target,
  output logic [AW-1:0] next_addr
);
  localparam int EXT = AW - OW;

  logic [AW-1:0] off_ext;
  logic [AW-1:0] off_bytes;

  always_comb begin
    off_ext   = {{EXT{offset[OW-1]}}, offset};
    off_bytes = {off_ext[AW-3:0], 2'b00};
    target    = addr + AW'(8) + off_bytes;
    next_addr = addr + AW'(4);
  end
endmodule

// File: rtl/bx_plan.sv
module bx_plan #(
  parameter int AW = 32
) (
  input  logic [3:0]       cond,
  input  logic             link,
  input  logic             backward,
  input  logic [AW-1:0]    target,
  input  logic [AW-1:0]    next_addr,
  output logic             take,
  output logic [1:0]       n_ops,
  output bx_pkg::uop_ctl_t ctl0,
  output logic [AW-1:0]    val0,
  output bx_pkg::uop_ctl_t ctl1,
  output logic [AW-1:0]    val1
);
  import bx_pkg::*;

  logic always_c;

  always_comb begin
    always_c = (cond == COND_ALWAYS);
    take     = 1'b1;
    n_ops    = 2'd0;
    ctl0     = '{cond: cond, to_link: 1'b0, flush: 1'b0};
    val0     = next_addr;
    ctl1     = '{cond: cond, to_link: 1'b1, flush: 1'b0};
    val1     = next_addr;
    if (always_c) begin
      if (link) begin
        n_ops        = 2'd1;
        ctl0.to_link = 1'b1;
      end
    end else if (link) begin
      n_ops      = 2'd2;
      ctl0.cond  = cond_invert(cond);
      ctl0.flush = 1'b1;
    end else if (backward) begin
      n_ops      = 2'd1;
      ctl0.cond  = cond_invert(cond);
      ctl0.flush = 1'b1;
    end else begin
      take       = 1'b0;
      n_ops      = 2'd1;
      ctl0.flush = 1'b1;
      val0       = target;
    end
  end
endmodule

// File: rtl/bx_queue.sv
module bx_queue #(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [1:0]       load_n,
  input  bx_pkg::uop_ctl_t ctl0,
  input  logic [AW-1:0]    val0,
  input  bx_pkg::uop_ctl_t ctl1,
  input  logic [AW-1:0]    val1,
  input  logic             pop,
  output logic             empty,
  output bx_pkg::uop_ctl_t head_ctl,
  output logic [AW-1:0]    head_val
);
  import bx_pkg::*;

  logic [1:0]    cnt_q, cnt_d;
  uop_ctl_t      ctl_q [2];
  logic [AW-1:0] val_q [2];
  uop_ctl_t      ctl_d [2];
  logic [AW-1:0] val_d [2];
  logic          slot_en;

  always_comb begin
    cnt_d   = cnt_q;
    ctl_d   = ctl_q;
    val_d   = val_q;
    slot_en = 1'b0;
    if (load) begin
      cnt_d    = load_n;
      ctl_d[0] = ctl0;
      val_d[0] = val0;
      ctl_d[1] = ctl1;
      val_d[1] = val1;
      slot_en  = 1'b1;
    end else if (pop && cnt_q != 2'd0) begin
      cnt_d    = cnt_q - 2'd1;
      ctl_d[0] = ctl_q[1];
      val_d[0] = val_q[1];
      slot_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= 2'd0;
    else        cnt_q <= cnt_d;
  end

  for (genvar s = 0; s < 2; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (slot_en) begin
        ctl_q[s] <= ctl_d[s];
        val_q[s] <= val_d[s];
      end
    end
  end

  assign empty    = (cnt_q == 2'd0);
  assign head_ctl = ctl_q[0];
  assign head_val = val_q[0];
endmodule

// File: rtl/bx_expander.sv
module bx_expander #(
  parameter int AW = 32,
  parameter int OW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    in_cond,
  input  logic          in_link,
  input  logic [OW-1:0] in_offset,
  input  logic [AW-1:0] in_addr,
  output logic          redir_valid,
  output logic [AW-1:0] redir_pc,
  output logic          uop_valid,
  input  logic          uop_ready,
  output logic [3:0]    uop_cond,
  output logic          uop_to_link,
  output logic          uop_flush,
  output logic [AW-1:0] uop_value
);
  import bx_pkg::*;

  logic [AW-1:0] target, next_addr;
  logic          take, accept, empty;
  logic [1:0]    n_ops;
  uop_ctl_t      ctl0, ctl1, head_ctl;
  logic [AW-1:0] val0, val1, head_val;
  logic          redir_valid_d;
  logic          redir_pc_en;

  bx_target #(.AW(AW), .OW(OW)) u_target (
    .addr(in_addr), .offset(in_offset), .target(target), .next_addr(next_addr)
  );

  bx_plan #(.AW(AW)) u_plan (
    .cond(in_cond), .link(in_link), .backward(in_offset[OW-1]),
    .target(target), .next_addr(next_addr), .take(take), .n_ops(n_ops),
    .ctl0(ctl0), .val0(val0), .ctl1(ctl1), .val1(val1)
  );

  assign in_ready = empty;
  assign accept   = in_valid && in_ready;

  bx_queue #(.AW(AW)) u_queue (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_n(n_ops),
    .ctl0(ctl0), .val0(val0), .ctl1(ctl1), .val1(val1),
    .pop(uop_ready), .empty(empty), .head_ctl(head_ctl), .head_val(head_val)
  );

  always_comb begin
    redir_valid_d = accept && take;
    redir_pc_en   = redir_valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) redir_valid <= 1'b0;
    else        redir_valid <= redir_valid_d;
  end

  always_ff @(posedge clk) begin
    if (redir_pc_en) redir_pc <= target;
  end

  assign uop_valid   = !empty;
  assign uop_cond    = head_ctl.cond;
  assign uop_to_link = head_ctl.to_link;
  assign uop_flush   = head_ctl.flush;
  assign uop_value   = head_val;
endmodule

// File: rtl/bx_expander_chk.sv
module bx_expander_chk #(
  parameter int AW = 32,
  parameter int OW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [3:0]    in_cond,
  input logic          in_link,
  input logic [OW-1:0] in_offset,
  input logic [AW-1:0] in_addr,
  input logic          redir_valid,
  input logic [AW-1:0] redir_pc,
  input logic          uop_valid,
  input logic          uop_ready,
  input logic [3:0]    uop_cond,
  input logic          uop_to_link,
  input logic          uop_flush,
  input logic [AW-1:0] uop_value
);
  logic          acc;
  logic [AW-1:0] exp_dest;

  assign acc      = in_valid && in_ready;
  assign exp_dest = in_addr + AW'(8) + AW'({{(AW-OW){in_offset[OW-1]}}, in_offset} << 2);

  // R2
  redir_only_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !redir_valid);

  // R2
  redir_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (!redir_valid || redir_pc == $past(exp_dest)));

  // R8
  no_intake_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid |-> !in_ready);

  // R8
  stall_holds_uop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_cond) && $stable(uop_to_link)
                                   && $stable(uop_flush) && $stable(uop_value)));

  // R6
  link_write_no_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_to_link) |-> !uop_flush);

  // R9
  idle_without_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!uop_valid && !acc) |=> !uop_valid);
endmodule

bind bx_expander bx_expander_chk #(.AW(AW), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_cond(in_cond), .in_link(in_link), .in_offset(in_offset), .in_addr(in_addr),
  .redir_valid(redir_valid), .redir_pc(redir_pc), .uop_valid(uop_valid),
  .uop_ready(uop_ready), .uop_cond(uop_cond), .uop_to_link(uop_to_link),
  .uop_flush(uop_flush), .uop_value(uop_value)
);

// File: tb/sim_bx_expander.sv
module sim_bx_expander;
  localparam int AW = 16;
  localparam int OW = 8;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [3:0]    in_cond;
  logic          in_link;
  logic [OW-1:0] in_offset;
  logic [AW-1:0] in_addr;
  logic          redir_valid;
  logic [AW-1:0] redir_pc;
  logic          uop_valid;
  logic          uop_ready;
  logic [3:0]    uop_cond;
  logic          uop_to_link;
  logic          uop_flush;
  logic [AW-1:0] uop_value;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  bx_expander #(.AW(AW), .OW(OW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cond(in_cond), .in_link(in_link), .in_offset(in_offset), .in_addr(in_addr),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .uop_valid(uop_valid),
    .uop_ready(uop_ready), .uop_cond(uop_cond), .uop_to_link(uop_to_link),
    .uop_flush(uop_flush), .uop_value(uop_value)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Compare the offered micro-op, then transfer it
  task automatic take_uop(input string req, input int c, input bit lk, input bit fl, input int v);
    check(uop_valid == 1'b1, req, uop_valid, 1);
    check(uop_cond == 4'(c), req, uop_cond, c);
    check(uop_to_link == lk, req, uop_to_link, lk);
    check(uop_flush == fl, req, uop_flush, fl);
    check(uop_value == AW'(v), req, uop_value, v);
    uop_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    uop_ready = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_cond = '0; in_link = 1'b0;
    in_offset = '0; in_addr = '0; uop_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(redir_valid == 1'b0, "R1", redir_valid, 0);
    check(uop_valid == 1'b0, "R1", uop_valid, 0);
    check(in_ready == 1'b1, "R1", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int c = 0; c < 16; c++) begin
      for (int lk = 0; lk < 2; lk++) begin
        for (int o = 0; o < 256; o++) begin
          int addr, so, dest, nxt, inv;
          bit always_c, back, exp_take;
          int nops;
          string rq;
          addr = ((c * 4099 + lk * 977 + o * 131) * 4) & 16'hFFFC;
          so   = (o > 127) ? o - 256 : o;
          dest = (addr + 8 + so * 4) & 16'hFFFF;
          nxt  = (addr + 4) & 16'hFFFF;
          inv  = c ^ 1;
          always_c = (c == 14);
          back     = (so < 0);
          exp_take = always_c || lk == 1 || back;
          if (always_c && lk == 0)      begin nops = 0; rq = "R3"; end
          else if (always_c)            begin nops = 1; rq = "R6"; end
          else if (lk == 1)             begin nops = 2; rq = "R7"; end
          else if (back)                begin nops = 1; rq = "R4"; end
          else                          begin nops = 1; rq = "R5"; end

          in_valid = 1'b1; in_cond = 4'(c); in_link = lk[0];
          in_offset = OW'(o); in_addr = AW'(addr);
          @(posedge clk);
          @(negedge clk);
          in_valid = 1'b0;
          check(redir_valid == exp_take, rq, redir_valid, exp_take);
          if (exp_take) check(redir_pc == AW'(dest), "R2", redir_pc, dest);
          check(uop_valid == (nops != 0), rq, uop_valid, nops != 0);
          check(in_ready == (nops == 0), "R8", in_ready, nops == 0);

          // R8: offer another branch while ops are pending; it must be ignored
          if (nops == 2 && (o % 16) == 3) begin
            in_valid = 1'b1; in_cond = 4'hE; in_link = 1'b1;
            in_offset = OW'(o + 7); in_addr = AW'(addr ^ 16'h0F00);
            @(posedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            check(redir_valid == 1'b0, "R8", redir_valid, 0);
            check(uop_cond == 4'(inv), "R8", uop_cond, inv);
            check(uop_value == AW'(nxt), "R8", uop_value, nxt);
          end else if (nops != 0) begin
            @(negedge clk);
            check(redir_valid == 1'b0, "R2", redir_valid, 0);
          end

          if (rq == "R4") take_uop("R4", inv, 1'b0, 1'b1, nxt);
          if (rq == "R5") take_uop("R5", c, 1'b0, 1'b1, dest);
          if (rq == "R6") take_uop("R6", 14, 1'b1, 1'b0, nxt);
          if (rq == "R7") begin
            take_uop("R7", inv, 1'b0, 1'b1, nxt);
            take_uop("R7", c, 1'b1, 1'b0, nxt);
          end
          // R9 queue drained
          check(uop_valid == 1'b0, "R9", uop_valid, 0);
          check(in_ready == 1'b1, "R9", in_ready, 1);
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule